// File: doc/BRIEF.md
# Dual-Bank Programmable Clock Divider

This block turns one selected reference into two divided clock enables: a voice/PCM-rate pulse and a hi-fi-rate pulse. All logic runs on a single system clock. Each possible reference is presented as an enable input that is high for one system cycle per reference period. There are three references: external input A, external input B and a PLL output.

Two 7-bit divider settings are held in a small register file. One setting applies when the reference is external, the other when it is the PLL. Software can therefore load the ratio for the idle path first and then flip the source select, so the new ratio arrives together with the new reference.

A change of input or source selection is handled by a two-state controller. In state ST_RUN, the selected reference ticks are passed to the dividers. When a register write makes the requested selection differ from the committed one, the transition RUN→SETTLE is taken. In state ST_SETTLE, ticks are dropped for a fixed number of system cycles. The transition SETTLE→RUN then commits the requested input and source, after which the dividers resume.

Top module: `clkdiv_dual_bank`

## Requirements
- R1: After reset, both enable outputs are low and `pll_pwrdn` is 1. External input A is the committed reference with the external bank in use, and both banks hold 0.
- R2: A write to address 0x44 loads the following: data[6:0] into the external bank, data[8] as input select (0 = A, 1 = B) and data[9] as source select (1 = external, 0 = PLL). A write to address 0x46 loads data[6:0] into the PLL bank and data[7] into `pll_pwrdn`. Writes to any other address change nothing.
- R3: With value N in bits [3:0] of the bank in use, `voice_en` pulses once every N+1 selected reference ticks (ratios 1 to 16).
- R4: With value N in bits [6:4] of the bank in use, `hifi_en` pulses once every N+1 selected reference ticks (ratios 1 to 8).
- R5: The bank in use is the PLL bank when the committed source is 0 and the external bank when it is 1. Writing the other bank does not alter the output spacing.
- R6: When the committed source is external, the input select picks whether A or B ticks drive the dividers.
- R7: A new value in the bank in use, or a source switch, is picked up only at the next terminal count of each divider, so the interval in progress keeps its old length.
- R8: A change of requested input or source enters ST_SETTLE for SETTLE_CYCLES system cycles. No enable pulse results from ticks in that window. The new selection is committed on the SETTLE→RUN transition.
- R9: Each enable pulse is high for one system cycle, one cycle after the reference tick that ends the count.
- R10: `pll_pwrdn` follows the last value written to bit 7 at address 0x46.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_a_tick | input | 1 | One-cycle tick per period of external input A |
| ext_b_tick | input | 1 | One-cycle tick per period of external input B |
| pll_tick | input | 1 | One-cycle tick per period of the PLL output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | DATA_W | Register write data |
| voice_en | output | 1 | Voice/PCM-rate clock enable pulse |
| hifi_en | output | 1 | Hi-fi-rate clock enable pulse |
| pll_pwrdn | output | 1 | PLL power-down control bit |

## Verification
The bench builds the block with the default 4-bit voice and 3-bit hi-fi fields, which makes the full ratio range of 1 to 16 and 1 to 8 reachable. It sets SETTLE_CYCLES to 3 rather than the default 2, so that the length of the dropped-tick window is visibly a parameter and not a fixed constant. Inputs A, B and the PLL tick at different periods (2, 3 and 1 system cycles), so each measured spacing shows both which reference and which bank is in use.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } sel_state_e;

    localparam logic [7:0] EXT_REG_ADDR = 8'h44;
    localparam logic [7:0] PLL_REG_ADDR = 8'h46;

    localparam int PWRDN_BIT = 7;
    localparam int MUX_BIT   = 8;
    localparam int SRC_BIT   = 9;

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DIV_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DIV_W-1:0]  ext_div,
    output logic [DIV_W-1:0]  pll_div,
    output logic              mux_b,
    output logic              src_ext,
    output logic              pll_pwrdn
);

    logic hit_ext;
    logic hit_pll;
    logic unused_data_ok;

    assign hit_ext        = wr_en && (wr_addr == EXT_REG_ADDR);
    assign hit_pll        = wr_en && (wr_addr == PLL_REG_ADDR);
    assign unused_data_ok = ^wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_div   <= '0;
            pll_div   <= '0;
            mux_b     <= 1'b0;
            src_ext   <= 1'b1;
            pll_pwrdn <= 1'b1;
        end else begin
            if (hit_ext) begin
                ext_div <= wr_data[DIV_W-1:0];
                mux_b   <= wr_data[MUX_BIT];
                src_ext <= wr_data[SRC_BIT];
            end
            if (hit_pll) begin
                pll_div   <= wr_data[DIV_W-1:0];
                pll_pwrdn <= wr_data[PWRDN_BIT];
            end
        end
    end

endmodule

// File: rtl/clkdiv_ref_sel.sv
module clkdiv_ref_sel
    import clkdiv_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_src_ext,
    input  logic req_mux_b,
    input  logic tick_a,
    input  logic tick_b,
    input  logic tick_pll,
    output logic gated_tick,
    output logic in_settle,
    output logic act_src_ext,
    output logic act_mux_b
);

    localparam int CW = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    sel_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          changed;
    logic          sel_tick;

    assign changed = (req_src_ext != act_src_ext) || (req_mux_b != act_mux_b);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    state_d = changed ? ST_SETTLE : ST_RUN;
            ST_SETTLE: state_d = (cnt_q == LAST) ? ST_RUN : ST_SETTLE;
            default:   state_d = ST_RUN;
        endcase
    end

    // state register, settle counter and committed selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            cnt_q       <= '0;
            act_src_ext <= 1'b1;
            act_mux_b   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_SETTLE) ? cnt_q + CW'(1) : '0;
            if (state_q == ST_SETTLE && state_d == ST_RUN) begin
                act_src_ext <= req_src_ext;
                act_mux_b   <= req_mux_b;
            end
        end
    end

    // outputs
    always_comb begin
        sel_tick   = act_src_ext ? (act_mux_b ? tick_b : tick_a) : tick_pll;
        in_settle  = (state_q == ST_SETTLE);
        gated_tick = sel_tick && (state_q == ST_RUN);
    end

endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic         pulse
);

    logic [W-1:0] cnt_q;
    logic         at_term;

    assign at_term = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= tick && at_term;
            if (tick) begin
                cnt_q <= at_term ? reload : cnt_q - W'(1);
            end
        end
    end

endmodule

// File: rtl/clkdiv_dual_bank.sv
module clkdiv_dual_bank #(
    parameter int VOICE_W       = 4,
    parameter int HIFI_W        = 3,
    parameter int DATA_W        = 16,
    parameter int SETTLE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_a_tick,
    input  logic              ext_b_tick,
    input  logic              pll_tick,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              voice_en,
    output logic              hifi_en,
    output logic              pll_pwrdn
);

    localparam int DIV_W = VOICE_W + HIFI_W;

    logic [DIV_W-1:0] ext_div;
    logic [DIV_W-1:0] pll_div;
    logic [DIV_W-1:0] act_div;
    logic             mux_b;
    logic             src_ext;
    logic             gated_tick;
    logic             in_settle;
    logic             act_src_ext;
    logic             act_mux_b;

    clkdiv_regs #(
        .DIV_W (DIV_W),
        .DATA_W(DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ext_div  (ext_div),
        .pll_div  (pll_div),
        .mux_b    (mux_b),
        .src_ext  (src_ext),
        .pll_pwrdn(pll_pwrdn)
    );

    clkdiv_ref_sel #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) sel_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_src_ext(src_ext),
        .req_mux_b  (mux_b),
        .tick_a     (ext_a_tick),
        .tick_b     (ext_b_tick),
        .tick_pll   (pll_tick),
        .gated_tick (gated_tick),
        .in_settle  (in_settle),
        .act_src_ext(act_src_ext),
        .act_mux_b  (act_mux_b)
    );

    assign act_div = act_src_ext ? ext_div : pll_div;

    clkdiv_lane #(.W(VOICE_W)) voice_lane_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (gated_tick),
        .reload(act_div[VOICE_W-1:0]),
        .pulse (voice_en)
    );

    clkdiv_lane #(.W(HIFI_W)) hifi_lane_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (gated_tick),
        .reload(act_div[DIV_W-1:VOICE_W]),
        .pulse (hifi_en)
    );

endmodule

// File: rtl/clkdiv_dual_bank_chk.sv
module clkdiv_dual_bank_chk
    import clkdiv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic       voice_en,
    input logic       hifi_en,
    input logic       pll_pwrdn,
    input logic       gated_tick,
    input logic       in_settle,
    input logic       act_src_ext,
    input logic       act_mux_b
);

    AST_VOICE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        voice_en |-> $past(gated_tick)); // R9

    AST_HIFI_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        hifi_en |-> $past(gated_tick)); // R9

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_settle) |-> (!voice_en && !hifi_en)); // R8

    AST_COMMIT_VIA_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({act_src_ext, act_mux_b}) |-> $past(in_settle)); // R8

    AST_PWRDN_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_pwrdn) |-> $past(wr_en && wr_addr == PLL_REG_ADDR)); // R10

endmodule

bind clkdiv_dual_bank clkdiv_dual_bank_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .voice_en   (voice_en),
    .hifi_en    (hifi_en),
    .pll_pwrdn  (pll_pwrdn),
    .gated_tick (gated_tick),
    .in_settle  (in_settle),
    .act_src_ext(act_src_ext),
    .act_mux_b  (act_mux_b)
);

// File: tb/clkdiv_dual_bank_tb.sv
module clkdiv_dual_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 3;
    localparam int PER_A      = 2;
    localparam int PER_B      = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_a_tick = 1'b0;
    logic        ext_b_tick = 1'b0;
    logic        pll_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        voice_en;
    logic        hifi_en;
    logic        pll_pwrdn;

    int checks = 0;
    int errors = 0;
    int ca = 0;
    int cb = 0;

    clkdiv_dual_bank #(
        .VOICE_W(4), .HIFI_W(3), .DATA_W(16), .SETTLE_CYCLES(SETTLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ext_a_tick(ext_a_tick), .ext_b_tick(ext_b_tick), .pll_tick(pll_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .voice_en(voice_en), .hifi_en(hifi_en), .pll_pwrdn(pll_pwrdn)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference tick generators: A every 2, B every 3, PLL every cycle
    always @(negedge clk) begin
        ca = (ca + 1) % PER_A;
        cb = (cb + 1) % PER_B;
        ext_a_tick <= (ca == 0);
        ext_b_tick <= (cb == 0);
        pll_tick   <= 1'b1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(input bit hifi);
        do @(negedge clk); while (!(hifi ? hifi_en : voice_en));
    endtask

    task automatic gap(input bit hifi, output int g);
        longint t0;
        wait_pulse(hifi);
        t0 = $time;
        wait_pulse(hifi);
        g = int'(($time - t0) / CLK_PERIOD);
    endtask

    task automatic expect_gaps(input string tag, input int vexp, input int hexp);
        int g;
        gap(1'b0, g);
        gap(1'b0, g);
        check({tag, " voice spacing"}, g, vexp);
        if (vexp > 1) begin
            wait_pulse(1'b0);
            @(negedge clk);
            check("R9 voice pulse width", int'(voice_en), 0);
        end
        gap(1'b1, g);
        gap(1'b1, g);
        check({tag, " hifi spacing"}, g, hexp);
        if (hexp > 1) begin
            wait_pulse(1'b1);
            @(negedge clk);
            check("R9 hifi pulse width", int'(hifi_en), 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 voice_en low", int'(voice_en), 0);
        check("R1 hifi_en low", int'(hifi_en), 0);
        check("R1 pll_pwrdn set", int'(pll_pwrdn), 1);
        rst_n = 1'b1;
        expect_gaps("R1 default ext bank on A", 2, 2);
    endtask

    task automatic t_ratio();
        reg_write(8'h44, 16'h0235);   // src ext, A, hifi 3, voice 5
        expect_gaps("R3 R4 mid ratio", 12, 8);
        reg_write(8'h44, 16'h027F);   // maximum ratios
        expect_gaps("R3 R4 max ratio", 32, 16);
    endtask

    task automatic t_mux();
        reg_write(8'h44, 16'h037F);   // input B
        expect_gaps("R6 input B", 48, 24);
    endtask

    task automatic t_preload();
        reg_write(8'h46, 16'h0092);   // PLL bank hifi 1 voice 2, power-down kept
        reg_write(8'h45, 16'h0000);   // unmapped address
        expect_gaps("R5 R2 idle bank and bad address", 48, 24);
        check("R2 pwrdn unchanged", int'(pll_pwrdn), 1);
    endtask

    task automatic t_switch();
        reg_write(8'h44, 16'h017F);   // source PLL
        expect_gaps("R5 PLL bank in use", 3, 2);
    endtask

    task automatic t_live();
        reg_write(8'h46, 16'h0000);   // ratio 1 both, PLL powered up
        check("R10 pwrdn cleared", int'(pll_pwrdn), 0);
        expect_gaps("R7 live write on active bank", 1, 1);
    endtask

    task automatic t_settle();
        int zeros = 0;
        reg_write(8'h44, 16'h0000);   // mux back to A, source stays PLL
        for (int i = 0; i < 12; i++) begin
            if (!voice_en) zeros++;
            @(negedge clk);
        end
        check("R8 dropped ticks in settle window", zeros, SETTLE);
    endtask

    task automatic t_terminal();
        int g;
        longint t0;
        reg_write(8'h44, 16'h0207);   // back to external A, voice 7, hifi 0
        expect_gaps("R5 R6 return to ext A", 16, 2);
        wait_pulse(1'b0);
        t0 = $time;
        reg_write(8'h44, 16'h0201);   // voice 1 mid-interval
        wait_pulse(1'b0);
        g = int'(($time - t0) / CLK_PERIOD);
        check("R7 interval in progress keeps old ratio", g, 16);
        gap(1'b0, g);
        check("R7 new ratio after terminal count", g, 4);
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pwrdn set by reset", int'(pll_pwrdn), 1);
        check("R1 voice_en low in reset", int'(voice_en), 0);
        rst_n = 1'b1;
        expect_gaps("R1 banks cleared by reset", 2, 2);
    endtask

    initial begin
        t_reset();
        t_ratio();
        t_mux();
        t_preload();
        t_switch();
        t_live();
        t_settle();
        t_terminal();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule